// File: doc/BRIEF.md
# Prescaled 8-bit compare-match timer

This block is an 8-bit up-counter that is clocked by a power-of-two prescaler. A byte-wide register port sets it up. The counter counts prescaled ticks. When the counter equals a programmable compare value on a tick, it starts again from zero and sets a sticky event flag. The interrupt request output follows that flag only while a separate enable bit is set. Software clears the flag by writing a one to it.

The same counter also drives a PWM output. The output is high while the count is below a programmable duty value. Software uses the block by choosing a divide code and enabling the prescaler, loading the compare and duty values, and setting the run bit. Every register read is registered: read data shows the register that was addressed in the previous cycle.

Top module: `tmr8_cmp_top`

## Requirements
- R1: After reset every register reads 0, and `irq_o` and `pwm_o` are 0.
- R2: Read data is registered and shows, one cycle later, the register at `bus_addr`. The addresses are 0 clock setup, 1 control, 2 count, 3 compare, 4 irq enable, 5 event flag and 6 duty. Address 7 reads 0. In the clock setup register, bit 0 is the prescaler enable and bits 3:1 are the divide code. Bits 7:4 always read 0.
- R3: With the enable bit at 1 and divide code k in 0..5, the running counter advances by one every 2^k clock cycles.
- R4: With divide code 6 or 7, or with the enable bit at 0, the counter does not advance.
- R5: While control bit 0 (run) is 0, the counter holds its value.
- R6: Writing control with bit 1 set clears the counter to 0, and this takes priority over a tick. Bit 1 reads back as 0.
- R7: On a tick while running with count equal to compare, the counter returns to 0. The count never exceeds the compare value once it has reached it.
- R8: The event flag (bit 0 of address 5) is set by the match of R7. It stays set until a write to address 5 with bit 0 at 1. Writing 0 has no effect, and a match in the same cycle as a clear leaves the flag set.
- R9: `irq_o` is 1 exactly when, in the previous cycle, the flag and the irq enable bit (bit 0 of address 4) were both 1.
- R10: `pwm_o` is 1 exactly when, in the previous cycle, the count was below the duty value. A duty of 0 keeps it low.
- R11: Writes to the count address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The bench sweeps every divide code and measures count growth over a fixed 32-cycle window. A wrong prescaler mask would give a wrong step. The reserved codes must freeze the counter, and a design that wraps the code into a valid ratio would be caught. Clear writes land on match cycles so that set-over-clear priority is tested: a design that lets the clear win loses an event. A zero duty value and an enable-off period check that the request and PWM lines never pulse when they should not.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned ADR_W = 3;
  localparam logic [ADR_W-1:0] ADR_CLK  = 3'd0;
  localparam logic [ADR_W-1:0] ADR_CTRL = 3'd1;
  localparam logic [ADR_W-1:0] ADR_CNT  = 3'd2;
  localparam logic [ADR_W-1:0] ADR_CMP  = 3'd3;
  localparam logic [ADR_W-1:0] ADR_IEN  = 3'd4;
  localparam logic [ADR_W-1:0] ADR_FLAG = 3'd5;
  localparam logic [ADR_W-1:0] ADR_DUTY = 3'd6;
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int unsigned DIV_W   = 3,
  parameter int unsigned DIV_MAX = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W = (DIV_MAX > 0) ? DIV_MAX : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             legal;

  assign legal  = en_i && (div_i <= DIV_W'(DIV_MAX));
  assign mask   = (PRE_W'(1) << div_i) - PRE_W'(1);
  assign tick_o = legal && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !legal) pre_q <= '0;
    else               pre_q <= pre_q + PRE_W'(1);
  end

  // R4
  reserved_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i || div_i > DIV_W'(DIV_MAX)) |-> !tick_o);
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step    = run_i && tick_i;
  assign match_o = step && (cnt_q == cmp_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (step)     cnt_q <= (cnt_q == cmp_i) ? '0 : cnt_q + CNT_W'(1);
  end

  // R5
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i) |=> $stable(cnt_o));
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0));
  // R7
  match_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |=> (cnt_o == '0));
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= (cnt_i < duty_i);
  end

  // R10
  pwm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (duty_i == '0) |=> !pwm_o);
endmodule

// File: rtl/tmr8_cmp_top.sv
module tmr8_cmp_top
  import tmr8_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_W   = 3,
  parameter int unsigned DIV_MAX = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              pwm_o
);
  localparam int unsigned CNT_W = DATA_W;
  localparam int unsigned PAD_W = DATA_W - DIV_W - 1;

  logic             en_q, run_q, ien_q, flag_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cmp_q, duty_q, cnt;
  logic             tick, match, cnt_clr, flag_clr;

  assign cnt_clr  = bus_we && (bus_addr == ADR_CTRL) && bus_wdata[1];
  assign flag_clr = bus_we && (bus_addr == ADR_FLAG) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; div_q <= '0; run_q <= 1'b0;
      cmp_q <= '0; ien_q <= 1'b0; duty_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        ADR_CLK:  begin en_q <= bus_wdata[0]; div_q <= bus_wdata[DIV_W:1]; end
        ADR_CTRL: run_q  <= bus_wdata[0];
        ADR_CMP:  cmp_q  <= bus_wdata;
        ADR_IEN:  ien_q  <= bus_wdata[0];
        ADR_DUTY: duty_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (match)    flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= flag_q && ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        ADR_CLK:  bus_rdata <= {{PAD_W{1'b0}}, div_q, en_q};
        ADR_CTRL: bus_rdata <= {{(DATA_W-1){1'b0}}, run_q};
        ADR_CNT:  bus_rdata <= cnt;
        ADR_CMP:  bus_rdata <= cmp_q;
        ADR_IEN:  bus_rdata <= {{(DATA_W-1){1'b0}}, ien_q};
        ADR_FLAG: bus_rdata <= {{(DATA_W-1){1'b0}}, flag_q};
        ADR_DUTY: bus_rdata <= duty_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  tmr8_prescaler #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_pre (
    .clk(clk), .rst(rst), .en_i(en_q), .div_i(div_q), .tick_o(tick));

  tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(run_q), .tick_i(tick), .clr_i(cnt_clr),
    .cmp_i(cmp_q), .cnt_o(cnt), .match_o(match));

  tmr8_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk(clk), .rst(rst), .cnt_i(cnt), .duty_i(duty_q), .pwm_o(pwm_o));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);
  // R8
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    match |=> flag_q);
  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && ien_q) |=> irq_o);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(flag_q && ien_q) |=> !irq_o);
  // R2
  clk_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADR_CLK) |=> (bus_rdata[DATA_W-1:DIV_W+1] == '0));
endmodule

// File: tb/test_tmr8_cmp_top.sv
module test_tmr8_cmp_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_o, pwm_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit chk_on = 1'b0;
  string rd_req = "R2";

  // reference model state
  int m_en, m_div, m_run, m_cnt, m_cmp, m_ien, m_flag, m_duty, m_pre;
  int m_rdata, m_irq, m_pwm;

  tmr8_cmp_top i_tmr8_cmp_top (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .pwm_o(pwm_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int rd_mux(int a);
    case (a)
      0: return m_div * 2 + m_en;
      1: return m_run;
      2: return m_cnt;
      3: return m_cmp;
      4: return m_ien;
      5: return m_flag;
      6: return m_duty;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int period, tick, match, wr, a, d;
    if (rst) begin
      m_en = 0; m_div = 0; m_run = 0; m_cnt = 0; m_cmp = 0; m_ien = 0;
      m_flag = 0; m_duty = 0; m_pre = 0; m_rdata = 0; m_irq = 0; m_pwm = 0;
    end else begin
      wr = bus_we; a = bus_addr; d = bus_wdata;
      m_rdata = rd_mux(a);
      m_irq   = m_flag & m_ien;
      m_pwm   = (m_cnt < m_duty) ? 1 : 0;
      period  = 1 << m_div;
      tick    = (m_en == 1 && m_div <= 5 && (m_pre % period) == period - 1) ? 1 : 0;
      m_pre   = (m_en == 0 || m_div > 5) ? 0 : (m_pre + 1) % 32;
      match   = (m_run == 1 && tick == 1 && m_cnt == m_cmp) ? 1 : 0;
      if (wr == 1 && a == 1 && d[1] == 1'b1) m_cnt = 0;
      else if (m_run == 1 && tick == 1) m_cnt = (m_cnt == m_cmp) ? 0 : (m_cnt + 1) % 256;
      if (match == 1) m_flag = 1;
      else if (wr == 1 && a == 5 && d[0] == 1'b1) m_flag = 0;
      if (wr == 1) begin
        case (a)
          0: begin m_en = d & 1; m_div = (d >> 1) & 7; end
          1: m_run = d & 1;
          3: m_cmp = d;
          4: m_ien = d & 1;
          6: m_duty = d;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      check(rd_req, bus_rdata, m_rdata);
      check("R9 irq", irq_o, m_irq);
      check("R10 pwm", pwm_o, m_pwm);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = 8'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    bus_addr = 3'(a); bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    int a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_on = 1'b1;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(i, a);
      check("R1 reset read", a, 0);
    end
    check("R1 irq", irq_o, 0);
    check("R1 pwm", pwm_o, 0);

    // R2 clock setup layout and padding; R4 reserved code
    rd_req = "R4";
    wr(0, 8'hFF);
    rd(0, a);
    check("R2 clk setup pad", a, 8'h0F);
    wr(1, 3);
    rd(2, a); repeat (10) @(negedge clk); rd(2, b);
    check("R4 reserved code holds", b, a);
    check("R4 reserved count zero", b, 0);
    wr(0, 8'h00);
    rd(2, a); repeat (10) @(negedge clk); rd(2, b);
    check("R4 enable off holds", b, a);

    // R3 divide ratios
    rd_req = "R3";
    wr(3, 255);
    for (int k = 0; k <= 5; k++) begin
      wr(0, (k << 1) | 1);
      wr(1, 3);
      rd(2, a); repeat (30) @(negedge clk); rd(2, b);
      check($sformatf("R3 step code %0d", k), b - a, 32 >> k);
    end

    // R5 hold while stopped
    rd_req = "R5";
    wr(0, 1);
    wr(1, 0);
    rd(2, a); repeat (12) @(negedge clk); rd(2, b);
    check("R5 stopped holds", b, a);

    // R11 count not writable
    rd_req = "R11";
    wr(2, 8'h55);
    rd(2, b);
    check("R11 count write ignored", b, a);

    // R6 clear, bit 1 reads back 0
    rd_req = "R6";
    wr(1, 2);
    rd(2, a);
    check("R6 cleared", a, 0);
    rd(1, a);
    check("R6 ctrl readback", a, 0);

    // R7 repeat at compare; R8 flag; R9 gating
    rd_req = "R7";
    wr(3, 3);
    wr(1, 1);
    for (int i = 0; i < 12; i++) begin
      rd(2, a);
      check("R7 count within compare", (a <= 3) ? 1 : 0, 1);
    end
    rd(5, a);
    check("R8 flag set", a, 1);
    check("R9 masked irq low", irq_o, 0);
    wr(4, 1);
    @(negedge clk);
    check("R9 irq high", irq_o, 1);
    rd_req = "R8";
    wr(1, 0);
    wr(5, 0);
    rd(5, a);
    check("R8 write zero no effect", a, 1);
    wr(5, 1);
    rd(5, a);
    check("R8 cleared", a, 0);
    @(negedge clk);
    check("R9 irq drops", irq_o, 0);

    // R8 clear hammered against matches: set must win
    wr(1, 1);
    @(negedge clk);
    bus_addr = 3'd5; bus_wdata = 8'd1; bus_we = 1'b1;
    repeat (24) @(negedge clk);
    bus_we = 1'b0;
    wr(4, 0);

    // R10 PWM with duty, then duty 0
    rd_req = "R10";
    wr(3, 7);
    wr(6, 3);
    repeat (40) @(negedge clk);
    wr(6, 0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check("R10 duty zero low", pwm_o, 0);
    end

    // R2 unused address
    rd_req = "R2";
    rd(7, a);
    check("R2 unused address", a, 0);

    chk_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule